// File: doc/BRIEF.md
# Processor Mode Controller

This block holds the operating mode of a 32-bit load-store processor core and derives the privilege level, the interrupt mask bits and the register-bank selection from it. Exception inputs move the core into the mode that belongs to each exception. On every entry the block keeps one level of saved state: the previous mode and the previous masks. An exception-return pulse brings that state back. Software can also change the mode through a status write port. Such a write takes effect only from a privileged mode and only when it carries a recognised encoding.

All inputs are sampled on the rising clock edge, and every output changes at that same edge. Exceptions outrank an exception return, and an exception return outranks a software write. One mode, the privileged system mode, can be reached only by a software write. The register file decodes the bank-select output to choose banked stack pointer and link registers. A bad encoding raises a one-cycle flag.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters supervisor mode (0x13). Both masks and the saved masks are cleared, the saved mode becomes supervisor, and the illegal flag is 0.
- R2: A supervisor call enters supervisor (0x13). An undefined instruction enters undefined mode (0x1B). A prefetch abort or a data abort enters abort mode (0x17).
- R3: A fast request taken while the fast mask is 0 enters fast-interrupt mode (0x11) and sets both masks. A normal request taken while the normal mask is 0 enters normal-interrupt mode (0x12) and sets only the normal mask. A request whose mask is 1 is ignored.
- R4: `priv_o` is 0 in user mode (0x10) and 1 in every other mode.
- R5: No exception enters system mode (0x1F). A software write of 0x1F from a privileged mode enters it, and system mode is privileged.
- R6: A software write made in user mode leaves the mode unchanged, even when the encoding is recognised.
- R7: `bank_sel_o` is 0 for both user and system mode. It is 1 for fast, 2 for normal, 3 for supervisor, 4 for abort and 5 for undefined.
- R8: When several exceptions arrive in the same cycle, the one taken is chosen in this order, highest first: data abort, unmasked fast request, unmasked normal request, prefetch abort, undefined instruction, supervisor call.
- R9: A write whose encoding is not one of the seven listed codes leaves the mode unchanged. It sets `bad_mode_o` for exactly the next cycle.
- R10: On each exception entry, the mode and masks held before entry are copied into the saved state, and `saved_mode_o` shows the saved mode.
- R11: In an exception mode, an exception-return pulse restores the saved mode and the saved masks. In user or system mode the pulse is ignored.
- R12: An exception taken in the same cycle as a return or a write wins, and that write is dropped without raising the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fint_req | input | 1 | Fast interrupt request |
| nint_req | input | 1 | Normal interrupt request |
| svc_call | input | 1 | Supervisor-call instruction executed |
| pf_abort | input | 1 | Prefetch abort |
| dt_abort | input | 1 | Data abort |
| undef_instr | input | 1 | Undefined instruction |
| exc_ret | input | 1 | Exception-return pulse |
| wr_en | input | 1 | Software mode-field write strobe |
| wr_mode | input | MODE_W | Mode code carried by the write |
| mode_o | output | MODE_W | Current mode code |
| priv_o | output | 1 | Current mode is privileged |
| saved_mode_o | output | MODE_W | Mode held before the last exception entry |
| bank_sel_o | output | BANK_W | Banked-register select code |
| fmask_o | output | 1 | Fast interrupt mask |
| nmask_o | output | 1 | Normal interrupt mask |
| bad_mode_o | output | 1 | One-cycle flag for an unrecognised write code |

## Verification
The hardest state to reach from the ports is a nested entry. A fast interrupt preempts a handler for a normal interrupt, and the return must then restore a half-masked state rather than the cleared state left by reset. The bench builds this in order: it takes a normal request, then a fast request, then issues a return. It checks that the normal mask stays set while the fast mask clears. It also stacks several exceptions into one cycle, removing the winner each time to walk the whole priority order. It places a software write in the same cycle as an exception to show that the write is silently dropped.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   localparam int PMC_MODE_W   = 5;
   localparam int PMC_BANK_MIN = 3;
   localparam int PMC_NSRC     = 6;

   typedef enum logic [PMC_MODE_W-1:0] {
      MD_USER   = 5'h10,
      MD_FAST   = 5'h11,
      MD_NORM   = 5'h12,
      MD_SUPER  = 5'h13,
      MD_ABORT  = 5'h17,
      MD_UNDEF  = 5'h1B,
      MD_SYSTEM = 5'h1F
   } pmc_mode_e;

   typedef struct packed {
      logic fmask;
      logic nmask;
   } pmc_mask_t;

   function automatic logic pmc_known(input logic [PMC_MODE_W-1:0] code);
      case (code)
         5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F: pmc_known = 1'b1;
         default: pmc_known = 1'b0;
      endcase
   endfunction

   function automatic logic pmc_priv(input pmc_mode_e m);
      pmc_priv = (m != MD_USER);
   endfunction

   function automatic logic pmc_exc_mode(input pmc_mode_e m);
      pmc_exc_mode = (m != MD_USER) && (m != MD_SYSTEM);
   endfunction

   function automatic logic [PMC_BANK_MIN-1:0] pmc_bank(input pmc_mode_e m);
      case (m)
         MD_FAST:  pmc_bank = 3'd1;
         MD_NORM:  pmc_bank = 3'd2;
         MD_SUPER: pmc_bank = 3'd3;
         MD_ABORT: pmc_bank = 3'd4;
         MD_UNDEF: pmc_bank = 3'd5;
         default:  pmc_bank = 3'd0;
      endcase
   endfunction

   // source index -> entry mode; index 0 is the highest priority
   function automatic pmc_mode_e pmc_src_mode(input int idx);
      case (idx)
         0:       pmc_src_mode = MD_ABORT;
         1:       pmc_src_mode = MD_FAST;
         2:       pmc_src_mode = MD_NORM;
         3:       pmc_src_mode = MD_ABORT;
         4:       pmc_src_mode = MD_UNDEF;
         default: pmc_src_mode = MD_SUPER;
      endcase
   endfunction

endpackage

// File: rtl/pmc_exc_arb.sv
module pmc_exc_arb
   import pmc_pkg::*;
#(
   parameter int NSRC = PMC_NSRC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   output logic            take,
   output pmc_mode_e       target
);

   logic [NSRC-1:0] grant;

   if (NSRC != PMC_NSRC) begin : g_bad_nsrc
      $error("pmc_exc_arb: NSRC must match the package source count");
   end

   assign grant[0] = req[0];
   for (genvar i = 1; i < NSRC; i++) begin : g_pri
      assign grant[i] = req[i] & ~(|req[i-1:0]);
   end

   assign take = |req;

   always_comb begin
      target = MD_SUPER;
      for (int i = 0; i < NSRC; i++) begin
         if (grant[i]) target = pmc_src_mode(i);
      end
   end

   // R8
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8
   top_src_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> (grant[0] && $countones(grant) == 1));

endmodule

// File: rtl/pmc_wr_gate.sv
module pmc_wr_gate
   import pmc_pkg::*;
#(
   parameter int MODE_W = PMC_MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_code,
   input  pmc_mode_e         cur_mode,
   input  logic              blocked,
   output logic              apply,
   output logic              bad,
   output pmc_mode_e         new_mode
);

   logic known;
   logic live;

   if (MODE_W != PMC_MODE_W) begin : g_bad_w
      $error("pmc_wr_gate: MODE_W must equal the package mode width");
   end

   assign known    = pmc_known(wr_code);
   assign live     = wr_en & ~blocked;
   assign apply    = live & known & pmc_priv(cur_mode);
   assign bad      = live & ~known;
   assign new_mode = pmc_mode_e'(wr_code);

   // R6
   user_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MD_USER) |-> !apply);

   // R9
   bad_never_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad |-> !apply);

endmodule

// File: rtl/pmc_bank_map.sv
module pmc_bank_map
   import pmc_pkg::*;
#(
   parameter int BANK_W  = PMC_BANK_MIN,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pmc_mode_e         mode_nxt,
   input  pmc_mode_e         mode_cur,
   output logic [BANK_W-1:0] bank
);

   if (BANK_W < PMC_BANK_MIN) begin : g_bad_w
      $error("pmc_bank_map: BANK_W too narrow for six bank codes");
   end

   if (REG_OUT) begin : g_reg
      logic [BANK_W-1:0] bank_q;
      always_ff @(posedge clk) begin
         if (!rst_n) bank_q <= BANK_W'(pmc_bank(MD_SUPER));
         else        bank_q <= BANK_W'(pmc_bank(mode_nxt));
      end
      assign bank = bank_q;
   end else begin : g_comb
      logic unused_nxt;
      assign unused_nxt = ^mode_nxt;
      assign bank = BANK_W'(pmc_bank(mode_cur));
   end

   // R7
   shared_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cur == MD_USER || mode_cur == MD_SYSTEM) |-> (bank == '0));

   // R7
   super_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cur == MD_SUPER) |-> (bank == BANK_W'(3)));

endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int MODE_W   = 5,
   parameter int BANK_W   = 3,
   parameter bit REG_BANK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fint_req,
   input  logic              nint_req,
   input  logic              svc_call,
   input  logic              pf_abort,
   input  logic              dt_abort,
   input  logic              undef_instr,
   input  logic              exc_ret,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   output logic [MODE_W-1:0] mode_o,
   output logic              priv_o,
   output logic [MODE_W-1:0] saved_mode_o,
   output logic [BANK_W-1:0] bank_sel_o,
   output logic              fmask_o,
   output logic              nmask_o,
   output logic              bad_mode_o
);

   localparam int NSRC = PMC_NSRC;

   if (MODE_W != PMC_MODE_W) begin : g_bad_mode_w
      $error("pmc_mode_ctrl: MODE_W must equal the package mode width");
   end
   if (BANK_W < PMC_BANK_MIN) begin : g_bad_bank_w
      $error("pmc_mode_ctrl: BANK_W below the minimum bank code width");
   end

   pmc_mode_e mode_q, mode_d, saved_q;
   pmc_mask_t mask_q, smask_q;
   logic      bad_q;

   logic [NSRC-1:0] req;
   logic            take;
   pmc_mode_e       target;
   logic            ret_ok;
   logic            wr_apply, wr_bad;
   pmc_mode_e       wr_target;

   // priority order: index 0 highest
   assign req[0] = dt_abort;
   assign req[1] = fint_req & ~mask_q.fmask;
   assign req[2] = nint_req & ~mask_q.nmask;
   assign req[3] = pf_abort;
   assign req[4] = undef_instr;
   assign req[5] = svc_call;

   pmc_exc_arb #(.NSRC(NSRC)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .take   (take),
      .target (target)
   );

   assign ret_ok = exc_ret & pmc_exc_mode(mode_q);

   pmc_wr_gate #(.MODE_W(MODE_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_code  (wr_mode),
      .cur_mode (mode_q),
      .blocked  (take | ret_ok),
      .apply    (wr_apply),
      .bad      (wr_bad),
      .new_mode (wr_target)
   );

   always_comb begin
      if (!rst_n)        mode_d = MD_SUPER;
      else if (take)     mode_d = target;
      else if (ret_ok)   mode_d = saved_q;
      else if (wr_apply) mode_d = wr_target;
      else               mode_d = mode_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MD_SUPER;
         saved_q <= MD_SUPER;
         mask_q  <= '0;
         smask_q <= '0;
         bad_q   <= 1'b0;
      end else begin
         mode_q <= mode_d;
         bad_q  <= wr_bad;
         if (take) begin
            saved_q <= mode_q;
            smask_q <= mask_q;
            if (target == MD_FAST) begin
               mask_q.fmask <= 1'b1;
               mask_q.nmask <= 1'b1;
            end else if (target == MD_NORM) begin
               mask_q.nmask <= 1'b1;
            end
         end else if (ret_ok) begin
            mask_q <= smask_q;
         end
      end
   end

   pmc_bank_map #(.BANK_W(BANK_W), .REG_OUT(REG_BANK)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_nxt (mode_d),
      .mode_cur (mode_q),
      .bank     (bank_sel_o)
   );

   assign mode_o       = mode_q;
   assign priv_o       = pmc_priv(mode_q);
   assign saved_mode_o = saved_q;
   assign fmask_o      = mask_q.fmask;
   assign nmask_o      = mask_q.nmask;
   assign bad_mode_o   = bad_q;

   // R3
   fast_entry_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fint_req && !fmask_o && !dt_abort) |=> (mode_o == MD_FAST && fmask_o && nmask_o));

   // R5
   no_system_by_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_abort || pf_abort || undef_instr || svc_call) |=> (mode_o != MD_SYSTEM));

   // R6
   user_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MD_USER && !dt_abort && !pf_abort && !undef_instr && !svc_call
       && !(fint_req && !fmask_o) && !(nint_req && !nmask_o)) |=> (mode_o == MD_USER));

   // R10
   entry_saves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_abort || svc_call) |=> (saved_mode_o == $past(mode_o)));

   // R11
   system_ret_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MD_SYSTEM && exc_ret && !wr_en && !dt_abort && !pf_abort
       && !undef_instr && !svc_call && !(fint_req && !fmask_o) && !(nint_req && !nmask_o))
      |=> (mode_o == MD_SYSTEM));

   // R9
   bad_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_mode_o |-> $past(wr_en));

   // R4
   priv_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      priv_o != (mode_o == MD_USER));

endmodule

// File: tb/tb_pmc_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_mode_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fint_req = 0, nint_req = 0, svc_call = 0, pf_abort = 0;
   logic       dt_abort = 0, undef_instr = 0, exc_ret = 0, wr_en = 0;
   logic [4:0] wr_mode = '0;
   logic [4:0] mode_o, saved_mode_o;
   logic [2:0] bank_sel_o;
   logic       priv_o, fmask_o, nmask_o, bad_mode_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pmc_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .fint_req(fint_req), .nint_req(nint_req),
      .svc_call(svc_call), .pf_abort(pf_abort), .dt_abort(dt_abort),
      .undef_instr(undef_instr), .exc_ret(exc_ret), .wr_en(wr_en), .wr_mode(wr_mode),
      .mode_o(mode_o), .priv_o(priv_o), .saved_mode_o(saved_mode_o),
      .bank_sel_o(bank_sel_o), .fmask_o(fmask_o), .nmask_o(nmask_o),
      .bad_mode_o(bad_mode_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      fint_req = 0; nint_req = 0; svc_call = 0; pf_abort = 0;
      dt_abort = 0; undef_instr = 0; exc_ret = 0; wr_en = 0; wr_mode = '0;
   endtask

   // inputs set before the call are seen by exactly one rising edge
   task automatic cyc();
      @(negedge clk);
      clear_in();
   endtask

   task automatic do_reset();
      clear_in();
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic write_mode(input logic [4:0] code);
      wr_en = 1; wr_mode = code;
      cyc();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 mode", mode_o, 5'h13);
      chk("R1 saved", saved_mode_o, 5'h13);
      chk("R1 masks", {fmask_o, nmask_o}, 2'b00);
      chk("R1 badflag", bad_mode_o, 0);
      chk("R7 super bank", bank_sel_o, 3);
      chk("R4 super priv", priv_o, 1);
   endtask

   task automatic t_user_writes();
      do_reset();
      write_mode(5'h10);
      chk("R4 user priv", priv_o, 0);
      chk("R7 user bank", bank_sel_o, 0);
      write_mode(5'h1F);
      chk("R6 user write ignored", mode_o, 5'h10);
      chk("R6 no flag", bad_mode_o, 0);
      write_mode(5'h05);
      chk("R9 flag set", bad_mode_o, 1);
      chk("R9 mode kept", mode_o, 5'h10);
      cyc();
      chk("R9 flag one cycle", bad_mode_o, 0);
      exc_ret = 1; cyc();
      chk("R11 ret in user ignored", mode_o, 5'h10);
   endtask

   task automatic t_sync_exc();
      do_reset();
      write_mode(5'h10);
      svc_call = 1; cyc();
      chk("R2 svc mode", mode_o, 5'h13);
      chk("R10 saved user", saved_mode_o, 5'h10);
      exc_ret = 1; cyc();
      chk("R11 ret to user", mode_o, 5'h10);
      undef_instr = 1; cyc();
      chk("R2 undef mode", mode_o, 5'h1B);
      chk("R7 undef bank", bank_sel_o, 5);
      pf_abort = 1; cyc();
      chk("R2 prefetch abort", mode_o, 5'h17);
      chk("R10 saved undef", saved_mode_o, 5'h1B);
      chk("R7 abort bank", bank_sel_o, 4);
      write_mode(5'h10);
      dt_abort = 1; cyc();
      chk("R2 data abort", mode_o, 5'h17);
   endtask

   task automatic t_interrupts();
      do_reset();
      write_mode(5'h10);
      nint_req = 1; cyc();
      chk("R3 normal mode", mode_o, 5'h12);
      chk("R3 normal masks", {fmask_o, nmask_o}, 2'b01);
      chk("R7 normal bank", bank_sel_o, 2);
      nint_req = 1; cyc();
      chk("R3 masked normal ignored", {mode_o, saved_mode_o}, {5'h12, 5'h10});
      fint_req = 1; cyc();
      chk("R3 fast mode", mode_o, 5'h11);
      chk("R3 fast masks", {fmask_o, nmask_o}, 2'b11);
      chk("R10 saved normal", saved_mode_o, 5'h12);
      chk("R7 fast bank", bank_sel_o, 1);
      fint_req = 1; nint_req = 1; cyc();
      chk("R3 masked fast ignored", mode_o, 5'h11);
      exc_ret = 1; cyc();
      chk("R11 nested ret mode", mode_o, 5'h12);
      chk("R11 nested ret masks", {fmask_o, nmask_o}, 2'b01);
   endtask

   task automatic t_priority();
      do_reset(); write_mode(5'h10);
      dt_abort = 1; fint_req = 1; nint_req = 1; pf_abort = 1; undef_instr = 1; svc_call = 1;
      cyc();
      chk("R8 data abort first", mode_o, 5'h17);
      do_reset(); write_mode(5'h10);
      fint_req = 1; nint_req = 1; pf_abort = 1; undef_instr = 1; svc_call = 1;
      cyc();
      chk("R8 fast second", mode_o, 5'h11);
      do_reset(); write_mode(5'h10);
      nint_req = 1; pf_abort = 1; undef_instr = 1; svc_call = 1;
      cyc();
      chk("R8 normal third", mode_o, 5'h12);
      do_reset(); write_mode(5'h10);
      pf_abort = 1; undef_instr = 1; svc_call = 1;
      cyc();
      chk("R8 prefetch fourth", mode_o, 5'h17);
      do_reset(); write_mode(5'h10);
      undef_instr = 1; svc_call = 1;
      cyc();
      chk("R8 undef over svc", mode_o, 5'h1B);
   endtask

   task automatic t_system();
      do_reset();
      write_mode(5'h1F);
      chk("R5 system mode", mode_o, 5'h1F);
      chk("R5 system priv", priv_o, 1);
      chk("R7 system bank", bank_sel_o, 0);
      exc_ret = 1; cyc();
      chk("R11 ret in system ignored", mode_o, 5'h1F);
      undef_instr = 1; cyc();
      chk("R5 exc leaves system", mode_o, 5'h1B);
      chk("R10 saved system", saved_mode_o, 5'h1F);
      exc_ret = 1; cyc();
      chk("R11 ret to system", mode_o, 5'h1F);
   endtask

   task automatic t_collide();
      do_reset();
      svc_call = 1; wr_en = 1; wr_mode = 5'h10; cyc();
      chk("R12 exc beats write", mode_o, 5'h13);
      chk("R12 saved", saved_mode_o, 5'h13);
      pf_abort = 1; wr_en = 1; wr_mode = 5'h07; cyc();
      chk("R12 dropped write no flag", {mode_o, 3'b000, bad_mode_o}, {5'h17, 3'b000, 1'b0});
      exc_ret = 1; nint_req = 1; cyc();
      chk("R12 exc beats return", mode_o, 5'h12);
      chk("R12 saved abort", saved_mode_o, 5'h17);
   endtask

   initial begin
      t_reset();
      t_user_writes();
      t_sync_exc();
      t_interrupts();
      t_priority();
      t_system();
      t_collide();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule